// File: doc/BRIEF.md
# Synchronous Slave-FIFO Write Master

This block streams 16-bit words from an on-chip valid/ready source into an external USB peripheral controller that exposes a synchronous slave-FIFO port. It drives the port's active-low chip select, write strobe and packet-end lines. It holds the output enable inactive and presents a fixed two-bit socket address on the address lines. The data bus is driven as a value plus an enable, so the pad ring can build the tri-state buffer. All logic runs on the interface clock, which may be as fast as 100 MHz or much slower.

Flow control comes from the peripheral's two active-low buffer flags, a full flag and a partial-full flag. Both are registered once. The combined throttle is then delayed by a configurable 0 to 3 extra cycles before it gates the source ready. A test mode ignores the flags altogether. When the source marks a word as last and the packet has not reached its configured size, the master pulses packet-end low together with that word's write strobe, which commits a short packet.

Top module: `sfm_write_master`

## Requirements
- R1: While reset is held, chip select, write strobe, packet-end and output enable are all high, and the data bus enable is low.
- R2: Output enable stays high at all times and the address lines always carry the SOCKET parameter (default 2'b00).
- R3: Chip select is low in the cycle after `enable` was sampled high, and high in the cycle after it was sampled low.
- R4: `src_ready` equals `enable` AND NOT (`flow_en` AND throttle), where throttle is the flag state defined in R6.
- R5: A handshake (`src_valid` and `src_ready` both high at a clock edge) drives the write strobe low for exactly the next cycle, with that word on the data bus. The write strobe is high in every other cycle.
- R6: Both flags are registered once. The throttle seen by R4 after a clock edge is the flag state that was presented FLAG_LAT+1 edges earlier.
- R7: Either flag being low (full or partial-full) throttles the source.
- R8: With `flow_en` low, the flags have no effect on `src_ready`.
- R9: Packet-end goes low in the same cycle as the write strobe of a word marked last, only when that word's position in its packet (counting from 1) is below PKT_WORDS. The position restarts after a last word, or after the PKT_WORDS-th word, which is committed with no packet-end pulse.
- R10: The data bus enable stays low until the first write strobe and then stays high until reset.
- R11: When the peripheral asserts its full flag with at least FLAG_LAT+2 free entries, no word is written into a full buffer, and the words arrive in source order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allow writes and select the port |
| flow_en | input | 1 | Use the flags for throttling (low = test mode) |
| src_data | input | DATA_W | Source word |
| src_valid | input | 1 | Source word valid |
| src_last | input | 1 | Source word ends a packet |
| src_ready | output | 1 | Master accepts the source word |
| port_full_n | input | 1 | Peripheral full flag, active low |
| port_pfull_n | input | 1 | Peripheral partial-full flag, active low |
| port_cs_n | output | 1 | Chip select, active low |
| port_wr_n | output | 1 | Write strobe, active low |
| port_oe_n | output | 1 | Output enable, held high |
| port_addr | output | 2 | Socket address |
| port_pktend_n | output | 1 | Packet-end, active low |
| port_dq | output | DATA_W | Data bus value |
| port_dq_oe | output | 1 | Data bus drive enable |

## Verification
Every strobe result is due exactly one cycle after the edge that sampled its cause: the write strobe, data, packet-end and chip select follow a handshake or the `enable` level of the previous edge. The throttle reaches `src_ready` FLAG_LAT+1 edges after the flag is presented. The bench drives inputs at the falling edge. It keeps the previous handshake and a shift history of the flag values it drove, and at the next falling edge it compares every port against the values those records predict. Ready is read one nanosecond after the inputs are driven, because it depends on them combinationally.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    // Flags as seen after the input register, active high.
    typedef struct packed {
        logic full;
        logic pfull;
    } flag_pair_t;

    // Registered port strobes.
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic pktend_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, pktend_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sfm_flag_sync.sv
module sfm_flag_sync #(
    parameter int LAT = 1   // extra delay stages, 0 to 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full_n,
    input  logic pfull_n,
    output logic throttle
);
    import sfm_pkg::*;

    flag_pair_t seen_d, seen_q;
    logic       raw_hit;

    always_comb begin
        seen_d.full  = ~full_n;
        seen_d.pfull = ~pfull_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    assign raw_hit = seen_q.full | seen_q.pfull;

    generate
        if (LAT == 0) begin : g_direct
            assign throttle = raw_hit;
        end else begin : g_delay
            logic [LAT-1:0] dly_d, dly_q;
            always_comb begin
                dly_d[0] = raw_hit;
                for (int i = 1; i < LAT; i++) dly_d[i] = dly_q[i-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '0;
                else        dly_q <= dly_d;
            end
            assign throttle = dly_q[LAT-1];
        end
    endgenerate

    // R6: a low flag is captured at the next edge.
    a_r6_flag_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n || !pfull_n) |=> (seen_q.full || seen_q.pfull));

endmodule

// File: rtl/sfm_pkt_tracker.sv
module sfm_pkt_tracker #(
    parameter int PKT_WORDS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs,
    input  logic last,
    output logic short_end
);
    localparam int CW = $clog2(PKT_WORDS + 1);
    localparam logic [CW-1:0] PKT_C = CW'(PKT_WORDS);

    logic [CW-1:0] cnt_d, cnt_q, pos;

    always_comb begin
        pos       = cnt_q + 1'b1;
        short_end = hs && last && (pos < PKT_C);
        cnt_d     = cnt_q;
        if (hs) cnt_d = (last || pos == PKT_C) ? '0 : pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: the position counter never reaches a full packet.
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < PKT_C);

endmodule

// File: rtl/sfm_port_drive.sv
module sfm_port_drive #(
    parameter int          DATA_W = 16,
    parameter logic [1:0]  SOCKET = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              hs,
    input  logic [DATA_W-1:0] word,
    input  logic              short_end,
    output logic              cs_n,
    output logic              wr_n,
    output logic              pktend_n,
    output logic              oe_n,
    output logic [1:0]        addr,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe
);
    import sfm_pkg::*;

    strobe_t           st_d, st_q;
    logic [DATA_W-1:0] dq_d, dq_q;

    always_comb begin
        st_d.cs_n     = ~enable;
        st_d.wr_n     = ~hs;
        st_d.pktend_n = ~short_end;
        st_d.dq_oe    = st_q.dq_oe | hs;
        dq_d          = hs ? word : dq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STROBE_IDLE;
            dq_q <= '0;
        end else begin
            st_q <= st_d;
            dq_q <= dq_d;
        end
    end

    assign cs_n     = st_q.cs_n;
    assign wr_n     = st_q.wr_n;
    assign pktend_n = st_q.pktend_n;
    assign dq_oe    = st_q.dq_oe;
    assign dq       = dq_q;
    assign oe_n     = 1'b1;
    assign addr     = SOCKET;

    // R5: a handshake puts the word on the bus with the strobe low.
    a_r5_wr_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> (!wr_n && dq == $past(word)));
    // R9: packet-end only travels with a write.
    a_r9_pktend_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !pktend_n |-> !wr_n);
    // R10: the bus drive, once on, stays on.
    a_r10_bus_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |=> dq_oe);

endmodule

// File: rtl/sfm_write_master.sv
module sfm_write_master #(
    parameter int         DATA_W    = 16,
    parameter int         PKT_WORDS = 512,
    parameter int         FLAG_LAT  = 1,
    parameter logic [1:0] SOCKET    = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flow_en,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    input  logic              src_last,
    output logic              src_ready,
    input  logic              port_full_n,
    input  logic              port_pfull_n,
    output logic              port_cs_n,
    output logic              port_wr_n,
    output logic              port_oe_n,
    output logic [1:0]        port_addr,
    output logic              port_pktend_n,
    output logic [DATA_W-1:0] port_dq,
    output logic              port_dq_oe
);
    logic throttle;
    logic hs;
    logic short_end;

    sfm_flag_sync #(.LAT(FLAG_LAT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_n   (port_full_n),
        .pfull_n  (port_pfull_n),
        .throttle (throttle)
    );

    assign src_ready = enable && !(flow_en && throttle);
    assign hs        = src_valid && src_ready;

    sfm_pkt_tracker #(.PKT_WORDS(PKT_WORDS)) u_pkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs        (hs),
        .last      (src_last),
        .short_end (short_end)
    );

    sfm_port_drive #(.DATA_W(DATA_W), .SOCKET(SOCKET)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .hs        (hs),
        .word      (src_data),
        .short_end (short_end),
        .cs_n      (port_cs_n),
        .wr_n      (port_wr_n),
        .pktend_n  (port_pktend_n),
        .oe_n      (port_oe_n),
        .addr      (port_addr),
        .dq        (port_dq),
        .dq_oe     (port_dq_oe)
    );

    // R3: chip select follows the sampled enable level.
    a_r3_select_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> !port_cs_n);
    // R5: no strobe without a preceding handshake.
    a_r5_no_spurious_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> port_wr_n);

endmodule

// File: tb/sfm_write_master_tb.sv
`timescale 1ns/1ps
module sfm_write_master_tb;
    localparam int DW   = 16;
    localparam int PKT  = 8;
    localparam int LAT  = 1;
    localparam int CAP  = 16;
    localparam int THR  = CAP - 2 - LAT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, flow_en = 1'b1;
    logic [DW-1:0] src_data = '0;
    logic src_valid = 1'b0, src_last = 1'b0;
    logic src_ready;
    logic port_full_n = 1'b1, port_pfull_n = 1'b1;
    logic port_cs_n, port_wr_n, port_oe_n, port_pktend_n, port_dq_oe;
    logic [1:0] port_addr;
    logic [DW-1:0] port_dq;

    always #2 clk = ~clk;

    sfm_write_master #(.DATA_W(DW), .PKT_WORDS(PKT), .FLAG_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flow_en(flow_en),
        .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
        .src_ready(src_ready), .port_full_n(port_full_n), .port_pfull_n(port_pfull_n),
        .port_cs_n(port_cs_n), .port_wr_n(port_wr_n), .port_oe_n(port_oe_n),
        .port_addr(port_addr), .port_pktend_n(port_pktend_n),
        .port_dq(port_dq), .port_dq_oe(port_dq_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model state
    bit prev_en, prev_hs, prev_short, wrote_any, thr_drv;
    logic [DW-1:0] prev_data;
    bit [3:0] hist;
    int bpos = 0;
    int fill = 0;
    logic [DW:0] exp_q[$];
    logic [DW:0] head;
    logic [15:0] lfsr = 16'hACE1;
    logic [DW-1:0] next_word = 16'h1000;

    initial begin
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            chk(port_cs_n && port_wr_n && port_pktend_n && port_oe_n, "R1", "strobes idle",
                {port_cs_n, port_wr_n, port_pktend_n, port_oe_n}, 4'hF);
            chk(!port_dq_oe, "R1", "bus released", port_dq_oe, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        prev_en = 0; prev_hs = 0; prev_short = 0; wrote_any = 0; thr_drv = 0; hist = '0;
        prev_data = '0;

        for (int cyc = 0; cyc < 1200; cyc++) begin
            bit drain, want_last, hs, thr_exp, rdy_exp;
            int p, plen;
            @(negedge clk);
            // outputs after the last edge
            if (prev_hs) wrote_any = 1;
            chk(port_cs_n == !prev_en, "R3", "chip select", port_cs_n, !prev_en);
            chk(port_wr_n == !prev_hs, "R5", "write strobe", port_wr_n, !prev_hs);
            if (prev_hs) chk(port_dq == prev_data, "R5", "data", port_dq, prev_data);
            chk(port_pktend_n == !prev_short, "R9", "packet end", port_pktend_n, !prev_short);
            chk(port_oe_n && port_addr == 2'b00, "R2", "oe/addr", {port_oe_n, port_addr}, 3'b100);
            chk(port_dq_oe == wrote_any, "R10", "bus enable", port_dq_oe, wrote_any);

            // peripheral buffer model
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (!port_wr_n) begin
                chk(fill < CAP, "R11", "write into full buffer", fill, CAP - 1);
                if (fill < CAP) fill++;
                if (exp_q.size() > 0) begin
                    head = exp_q.pop_front();
                    chk(port_dq == head[DW-1:0], "R11", "word order", port_dq, head[DW-1:0]);
                    chk(!port_pktend_n == head[DW], "R9", "commit with last word", !port_pktend_n, head[DW]);
                end else chk(0, "R11", "unexpected word", port_dq, 0);
            end
            if (cyc < 300)       drain = (cyc % 3 == 0);
            else if (cyc < 600) drain = lfsr[2];
            else                 drain = 1'b1;
            if (drain && fill > 0) fill--;
            port_full_n = (fill < THR);
            if (cyc >= 820 && cyc < 900)       port_pfull_n = 1'b0; // R8 window
            else if (cyc >= 980 && cyc < 1000) port_pfull_n = 1'b0; // R7 window
            else                               port_pfull_n = 1'b1;

            hist = {hist[2:0], thr_drv};
            thr_drv = !port_full_n || !port_pfull_n;

            // source stimulus
            flow_en = !(cyc >= 800 && cyc < 950);
            enable  = (cyc >= 600 && cyc < 750) ? cyc[4] : 1'b1;
            plen = (cyc < 300) ? 5 : ((cyc >= 700 && cyc < 750) ? 7 : 8);
            if (cyc < 300)       begin src_valid = 1; want_last = (bpos + 1 == plen); end
            else if (cyc < 600) begin src_valid = lfsr[0] | lfsr[1]; want_last = (lfsr[5:3] == 0); end
            else if (cyc < 750) begin src_valid = 1; want_last = (bpos + 1 == plen); end
            else if (cyc < 800) begin src_valid = 0; want_last = 0; end
            else if (cyc < 1100) begin src_valid = 1; want_last = 0; end
            else                 begin src_valid = 0; want_last = 0; end
            src_last = want_last;
            src_data = next_word;

            #1;
            thr_exp = flow_en && hist[LAT];
            rdy_exp = enable && !thr_exp;
            if (cyc >= 820 && cyc < 900)
                chk(src_ready == enable, "R8", "flags ignored", src_ready, enable);
            else if (cyc >= 982 && cyc < 1000)
                chk(!src_ready, "R7", "partial flag throttles", src_ready, 0);
            chk(src_ready == rdy_exp, "R4 R6", "source ready", src_ready, rdy_exp);
            hs = src_valid && src_ready;

            prev_en = enable;
            prev_hs = hs;
            prev_data = src_data;
            prev_short = 0;
            if (hs) begin
                p = bpos + 1;
                prev_short = src_last && (p < PKT);
                bpos = (src_last || p == PKT) ? 0 : p;
                exp_q.push_back({prev_short, src_data});
                next_word = next_word + 16'h0101;
            end
        end
        chk(exp_q.size() == 0, "R11", "all words delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule